// File: doc/BRIEF.md
# Cascadable Presettable Binary Counter

This block is a synchronous binary up-counter assembled from identical 4-bit cells. Each cell advances on the rising clock edge. It can be preset from a parallel data word, and it counts only when two active-high enables are both high. The cells are chained through their terminal-count outputs to form one wider counter. The enable `te` reaching cell 0 comes from outside. Every later cell takes its `te` from the terminal-count output of the cell below it. No gating logic is needed between cells.

Clearing is asynchronous and active low. Pulling `clear_n` low zeroes the whole count at once, with no clock edge needed, and overrides every other input. The release of clear is synchronised to the clock, so the count leaves zero only on a clean edge. A parallel load (`load_n` low) takes priority over both enables. The enables have unequal roles: `pe` gates counting only, while `te` gates both counting and the carry output. This allows a carry to ripple up the chain while counting is paused.

Each cell has one operating state that is re-decoded on every cycle. The three states are `OP_LOAD`, `OP_COUNT` and `OP_HOLD`.
- `OP_LOAD` is chosen whenever `load_n` is low.
- `OP_COUNT` is chosen when `load_n` is high and `pe` and `te` are both high.
- `OP_HOLD` is chosen in every other case.

On each edge the cell moves to the state chosen by these inputs. An asserted internal clear overrides all three states and forces the cell to zero.

Top module: `cnt_chain`

## Requirements
- R1: The count changes only on a rising clock edge. Changing `load_n`, `pe`, `te` or `data` between edges leaves `count` unchanged.
- R2: While `clear_n` is low, `count` is all zeros at once, without a clock edge, whatever the other inputs are.
- R3: With the internal clear released and `load_n` low, a rising edge copies `data` into `count` bit for bit (`data[i]` goes to `count[i]`, bit 0 is least significant), whatever `pe` and `te` are. This includes a load while the count is all ones and `te` is high.
- R4: With `load_n` high, a rising edge while `pe` and `te` are both high increments `count` by one as a single `TOTAL_W`-bit binary number.
- R5: With `load_n` high and either `pe` or `te` low, a rising edge leaves `count` unchanged.
- R6: Counting from all ones wraps to all zeros, and `carry` falls as soon as the count leaves all ones.
- R7: `carry` is combinational and equals `te` AND (every bit of `count` is 1). It does not depend on `pe`.
- R8: After `clear_n` returns high, `count` stays zero through the next `CLR_STAGES` (default 2) rising edges, ignoring load and enables. It responds normally from the edge after those.
- R9: A 4-bit cell above cell 0 advances only on an edge where every cell below it holds all ones, so the chain behaves as one binary counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the count advances on its rising edge |
| clear_n | input | 1 | Asynchronous clear, active low; its release is synchronised to `clk` |
| load_n | input | 1 | Synchronous parallel load, active low |
| pe | input | 1 | Count enable that gates counting only |
| te | input | 1 | Count enable that gates counting and the carry output |
| data | input | NUM_CELLS*CELL_W | Parallel preset word |
| count | output | NUM_CELLS*CELL_W | Current count |
| carry | output | 1 | Terminal count of the whole chain |

## Verification
The bench runs the counter through directed sequences and then through biased random traffic. The directed part loads values just below a cell boundary and near all ones, then counts up. This separates a correct chained increment (R9) and a correct wrap (R6) from a counter that rolls each cell over on its own. The bench toggles `pe` and `te` separately while the count sits at all ones. This shows that `carry` follows `te` alone and that either enable can hold the count. It loads while at all ones with `te` high, which separates load priority from counting. It drops `clear_n` in the middle of a cycle and then tries to load during the release window. This separates an immediate clear and a synchronised release from an edge-timed clear.

// File: rtl/cnt_pkg.sv
package cnt_pkg;

    // Per-cell operating state, decoded every cycle from the control inputs
    typedef enum logic [1:0] {
        OP_HOLD  = 2'd0,
        OP_COUNT = 2'd1,
        OP_LOAD  = 2'd2
    } cell_op_e;

endpackage

// File: rtl/clr_sync.sv
module clr_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic clear_n,
    output logic rst_n_sync
);
    logic [STAGES-1:0] stage_q;

    // Asserts at once, releases after STAGES rising edges
    always_ff @(posedge clk or negedge clear_n) begin
        if (!clear_n) begin
            stage_q <= '0;
        end else begin
            stage_q <= {stage_q[STAGES-2:0], 1'b1};
        end
    end

    assign rst_n_sync = stage_q[STAGES-1];
endmodule

// File: rtl/cnt_cell.sv
module cnt_cell
    import cnt_pkg::*;
#(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_n,
    input  logic         pe,
    input  logic         te,
    input  logic [W-1:0] d,
    output logic [W-1:0] q,
    output logic         tc
);
    cell_op_e     op;
    logic [W-1:0] q_next;

    // Operating-state decode: load wins over both enables
    always_comb begin
        if (!load_n) begin
            op = OP_LOAD;
        end else if (pe && te) begin
            op = OP_COUNT;
        end else begin
            op = OP_HOLD;
        end
    end

    always_comb begin
        unique case (op)
            OP_LOAD:  q_next = d;
            OP_COUNT: q_next = q + 1'b1;
            OP_HOLD:  q_next = q;
            default:  q_next = q;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= q_next;
        end
    end

    // Output process: terminal count is gated by te only
    always_comb begin
        tc = te && (&q);
    end
endmodule

// File: rtl/cnt_chain.sv
module cnt_chain #(
    parameter int NUM_CELLS  = 2,
    parameter int CELL_W     = 4,
    parameter int CLR_STAGES = 2,
    localparam int TOTAL_W   = NUM_CELLS * CELL_W
) (
    input  logic               clk,
    input  logic               clear_n,
    input  logic               load_n,
    input  logic               pe,
    input  logic               te,
    input  logic [TOTAL_W-1:0] data,
    output logic [TOTAL_W-1:0] count,
    output logic               carry
);
    logic               rst_sync_n;
    logic [NUM_CELLS:0] te_link;

    clr_sync #(.STAGES(CLR_STAGES)) u_clr (
        .clk        (clk),
        .clear_n    (clear_n),
        .rst_n_sync (rst_sync_n)
    );

    assign te_link[0] = te;

    for (genvar i = 0; i < NUM_CELLS; i++) begin : g_cell
        cnt_cell #(.W(CELL_W)) u_cell (
            .clk    (clk),
            .rst_n  (rst_sync_n),
            .load_n (load_n),
            .pe     (pe),
            .te     (te_link[i]),
            .d      (data[i*CELL_W +: CELL_W]),
            .q      (count[i*CELL_W +: CELL_W]),
            .tc     (te_link[i+1])
        );
    end

    assign carry = te_link[NUM_CELLS];
endmodule

// File: rtl/cnt_chain_chk.sv
module cnt_chain_chk #(
    parameter int TOTAL_W = 8
) (
    input logic               clk,
    input logic               clear_n,
    input logic               load_n,
    input logic               pe,
    input logic               te,
    input logic [TOTAL_W-1:0] data,
    input logic [TOTAL_W-1:0] count,
    input logic               carry,
    input logic               rst_ok
);
    AST_CLEAR_ZERO: assert property (@(negedge clk)
        !clear_n |-> count == '0); // R2

    AST_RELEASE_HOLD: assert property (@(posedge clk) disable iff (!clear_n)
        !rst_ok |=> count == '0); // R8

    AST_LOAD_COPY: assert property (@(posedge clk) disable iff (!clear_n)
        (rst_ok && !load_n) |=> count == $past(data)); // R3

    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!clear_n)
        (rst_ok && load_n && pe && te) |=> count == TOTAL_W'($past(count) + 1'b1)); // R4

    AST_HOLD_VALUE: assert property (@(posedge clk) disable iff (!clear_n)
        (rst_ok && load_n && !(pe && te)) |=> $stable(count)); // R5

    AST_CARRY_TERM: assert property (@(negedge clk) disable iff (!clear_n)
        carry == (te && (count == {TOTAL_W{1'b1}}))); // R7
endmodule

bind cnt_chain cnt_chain_chk #(.TOTAL_W(TOTAL_W)) u_chk (
    .clk     (clk),
    .clear_n (clear_n),
    .load_n  (load_n),
    .pe      (pe),
    .te      (te),
    .data    (data),
    .count   (count),
    .carry   (carry),
    .rst_ok  (rst_sync_n)
);

// File: tb/cnt_chain_test.sv
module cnt_chain_test;
    localparam int PERIOD = 10;
    localparam int W      = 8;
    localparam int HOLDN  = 2;

    logic         clk = 1'b0;
    logic         clear_n = 1'b0, load_n = 1'b1, pe = 1'b0, te = 1'b0;
    logic [W-1:0] data = '0;
    logic [W-1:0] count;
    logic         carry;

    int compared = 0;
    int mism     = 0;
    int m_cnt    = 0;   // reference count
    int rel      = 0;   // edges seen since clear release
    bit done     = 0;

    cnt_chain uut (
        .clk(clk), .clear_n(clear_n), .load_n(load_n), .pe(pe), .te(te),
        .data(data), .count(count), .carry(carry)
    );

    always #(PERIOD/2) clk = ~clk;

    task automatic chk(input string tag, input int act, input int exp);
        compared++;
        if (act != exp) begin
            mism++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // One cycle: drive at falling edge, check mid-cycle, check after rising edge
    task automatic cyc(input bit cl, input bit ld, input bit p, input bit t, input int d);
        string tag;
        @(negedge clk);
        clear_n = cl; load_n = ld; pe = p; te = t; data = W'(d);
        #1;
        if (!cl) begin
            m_cnt = 0; rel = 0;
            chk("R2 clear mid-cycle", int'(count), 0);
        end else begin
            chk("R1 no change between edges", int'(count), m_cnt);
        end
        chk("R7 carry", int'(carry), int'(t && m_cnt == 255));
        @(posedge clk);
        #1;
        if (!cl) begin
            tag = "R2 clear held";
        end else if (rel < HOLDN) begin
            rel++; tag = "R8 release window";
        end else if (!ld) begin
            m_cnt = d & 255; tag = "R3 load";
        end else if (p && t) begin
            if (m_cnt == 255) tag = "R6 wrap";
            else if ((m_cnt & 15) == 15) tag = "R9 cell chain";
            else tag = "R4 count";
            m_cnt = (m_cnt + 1) % 256;
        end else begin
            tag = "R5 hold";
        end
        chk(tag, int'(count), m_cnt);
    endtask

    initial begin
        #1;
        chk("R2 reset state", int'(count), 0);
        cyc(0, 1, 1, 1, 0);
        cyc(1, 0, 1, 1, 8'h55);          // R8: load ignored
        cyc(1, 0, 1, 1, 8'h55);          // R8
        cyc(1, 0, 0, 0, 8'hFD);          // R3 load, enables low
        cyc(1, 1, 1, 1, 0);              // R4
        cyc(1, 1, 0, 1, 0);              // R5 pe low
        cyc(1, 1, 1, 1, 0);              // reach FF
        cyc(1, 1, 0, 1, 0);              // R7 carry with pe low
        cyc(1, 1, 1, 0, 0);              // R7 carry low with te low, R5 hold
        cyc(1, 0, 1, 1, 8'h0F);          // R3 load at all ones, te high
        cyc(1, 1, 1, 1, 0);              // R9 0F -> 10
        cyc(1, 0, 1, 1, 8'hFF);
        cyc(1, 1, 1, 1, 0);              // R6 wrap
        cyc(1, 1, 1, 1, 0);
        cyc(0, 0, 1, 1, 8'hAA);          // R2 mid-cycle clear
        cyc(1, 0, 1, 1, 8'hAA);          // R8
        cyc(1, 0, 1, 1, 8'hAA);          // R8
        cyc(1, 0, 1, 1, 8'hEE);          // R3
        for (int i = 0; i < 4000; i++) begin
            int r = $urandom_range(99);
            cyc(r >= 2, $urandom_range(99) >= 8, $urandom_range(99) < 85,
                $urandom_range(99) < 85, int'($urandom_range(255)));
        end
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mism);
        $finish;
    end

    initial begin
        #(PERIOD * 200000);
        if (!done) begin
            compared++; mism++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mism);
            $finish;
        end
    end
endmodule